// File: doc/BRIEF.md
# Multi-Hart Debug Halt Group Controller

This block keeps the run-control state that a debug module holds for each hart: whether the hart is halted, whether it has acknowledged a resume, whether it has been reset since the debugger last acknowledged that, and which halt group it belongs to. The harts report three events as single-cycle pulses: entry into debug halt, leaving debug mode, and a hart reset. The block drives one halt-request line per hart.

Each halt group is a nonzero 5-bit number. When a hart that was running reports that it has halted, the block sends a halt request to every other running hart with the same nonzero group number. Harts can then be stopped at nearly the same time without the debugger writing to each one. A request made this way stays raised until its target reports halted. Group 0 means that the hart is in no group.

The debugger reaches the block through a small register port. Writes take effect on the clock edge and reads are combinational. A control register holds the hart select, a stored halt-request bit and two one-shot bits: resume-request and reset-acknowledge. A group register reads or writes the halt group of the selected hart. A read-only status register reports the state of the selected hart. The parameter NUM_HARTS must be at least 2.

Top module: `hgc_halt_group`

## Requirements
- R1: Register address 0 is the control register. Bits [15:0] are the hart select, bit 31 is the stored halt request, bit 30 is a resume-request pulse and bit 29 is a reset-acknowledge pulse. A written select is masked to the fewest bits that can encode NUM_HARTS values (3 bits for 5 harts). A read returns the masked select and bit 31, and bits 30 and 29 read as 0.
- R2: State is kept for every select value in the masked range, including harts that do not exist. A group written to a nonexistent hart reads back unchanged.
- R3: When a hart that was not halted reports halted and its group is nonzero, every other hart that is not halted and has the same group gets its halt request raised on the next cycle. Harts in other groups do not.
- R4: A hart in group 0 that halts raises no request. A halted notice from a hart that is already halted raises no request.
- R5: Register address 1 is the group register, with the group in bits [4:0] and a write enable in bit 31. A write changes the selected hart's group only when bit 31 is set. A read returns the selected hart's group.
- R6: A resuming notice clears the hart's halted flag and sets its resume-acknowledge flag. A control write with bit 30 set clears resume-acknowledge for the newly written select.
- R7: A hart reset sets have-reset, clears halted and sets the group to 0. A control write with bit 29 set clears have-reset for the newly written select.
- R8: Register address 2 is the status register. When the selected hart is halted, bits 0 and 1 (any/all halted) are set; otherwise bits 2 and 3 (any/all running) are set. Bit 4 is resume-acknowledge, and bits 5 and 6 (any/all have-reset) are the have-reset flag.
- R9: A group-raised request is held until its target reports halted or is reset. halt_req_o for a hart is that held request ORed with control bit 31 when the hart is selected.
- R10: When several harts report halted in the same cycle, the requests from every one of them are applied together.
- R11: After module reset every flag, group, select and request is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low module reset |
| hart_halted_i | input | NUM_HARTS | Per-hart pulse: the hart has entered debug halt |
| hart_resuming_i | input | NUM_HARTS | Per-hart pulse: the hart is leaving debug mode |
| hart_reset_i | input | NUM_HARTS | Per-hart pulse: the hart has been reset |
| halt_req_o | output | NUM_HARTS | Per-hart halt request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 control, 1 group, 2 status) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |

## Verification
The bench halts two harts from different groups in the same cycle. A design that lets one source overwrite the other would request only one of the two target pairs. It checks that a hart in group 0, and a hart that reports halted a second time, raise no requests; a design that ignores the group-0 exception or the "was running" condition would stop unrelated harts. It writes select values with high bits set and expects them to read back masked, and it writes to a nonexistent hart's group, where a design without the full range of state would lose the value. It also checks that held requests survive idle cycles, merge with the debugger's own request, and drop only when the target halts.

// File: rtl/hgc_pkg.sv
package hgc_pkg;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_GROUP  = 2'd1,
        REG_STATUS = 2'd2,
        REG_SPARE  = 2'd3
    } hgc_reg_e;

    localparam int HGC_GROUP_W       = 5;
    localparam int CTRL_SEL_FIELD_W  = 16;
    localparam int CTRL_HALTREQ_BIT  = 31;
    localparam int CTRL_RESUME_BIT   = 30;
    localparam int CTRL_ACKRST_BIT   = 29;
    localparam int GROUP_WE_BIT      = 31;

    localparam int ST_ANY_HALTED     = 0;
    localparam int ST_ALL_HALTED     = 1;
    localparam int ST_ANY_RUNNING    = 2;
    localparam int ST_ALL_RUNNING    = 3;
    localparam int ST_ALL_RESUMEACK  = 4;
    localparam int ST_ANY_HAVERESET  = 5;
    localparam int ST_ALL_HAVERESET  = 6;

    // Bits needed to encode n distinct select values.
    function automatic int sel_width(input int n);
        int bits;
        int rem;
        bits = 0;
        rem  = n - 1;
        while (rem > 0) begin
            bits++;
            rem = rem >> 1;
        end
        return bits;
    endfunction

endpackage

// File: rtl/hgc_regif.sv
module hgc_regif
    import hgc_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int GW    = 5
) (
    input  logic             wr_i,
    input  logic [1:0]       addr_i,
    input  logic [31:0]      wdata_i,
    input  logic [SEL_W-1:0] sel_q_i,
    input  logic             haltreq_q_i,
    input  logic             sel_halted_i,
    input  logic             sel_resumeack_i,
    input  logic             sel_havereset_i,
    input  logic [GW-1:0]    sel_group_i,
    output logic             ctrl_wr_o,
    output logic [SEL_W-1:0] wsel_o,
    output logic             whaltreq_o,
    output logic             resume_o,
    output logic             ackrst_o,
    output logic             grp_wr_o,
    output logic [GW-1:0]    grp_val_o,
    output logic [31:0]      rdata_o
);

    hgc_reg_e reg_sel;
    assign reg_sel = hgc_reg_e'(addr_i);

    logic unused_wbits;
    assign unused_wbits = ^wdata_i;

    // Write decode: control fields act on the written select.
    always_comb begin
        ctrl_wr_o  = wr_i && (reg_sel == REG_CTRL);
        wsel_o     = wdata_i[SEL_W-1:0];
        whaltreq_o = wdata_i[CTRL_HALTREQ_BIT];
        resume_o   = ctrl_wr_o && wdata_i[CTRL_RESUME_BIT];
        ackrst_o   = ctrl_wr_o && wdata_i[CTRL_ACKRST_BIT];
        grp_wr_o   = wr_i && (reg_sel == REG_GROUP) && wdata_i[GROUP_WE_BIT];
        grp_val_o  = wdata_i[GW-1:0];
    end

    // Read mux.
    always_comb begin
        rdata_o = '0;
        unique case (reg_sel)
            REG_CTRL: begin
                rdata_o[SEL_W-1:0]       = sel_q_i;
                rdata_o[CTRL_HALTREQ_BIT] = haltreq_q_i;
            end
            REG_GROUP: begin
                rdata_o[GW-1:0] = sel_group_i;
            end
            REG_STATUS: begin
                rdata_o[ST_ANY_HALTED]    = sel_halted_i;
                rdata_o[ST_ALL_HALTED]    = sel_halted_i;
                rdata_o[ST_ANY_RUNNING]   = !sel_halted_i;
                rdata_o[ST_ALL_RUNNING]   = !sel_halted_i;
                rdata_o[ST_ALL_RESUMEACK] = sel_resumeack_i;
                rdata_o[ST_ANY_HAVERESET] = sel_havereset_i;
                rdata_o[ST_ALL_HAVERESET] = sel_havereset_i;
            end
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/hgc_group_prop.sv
module hgc_group_prop #(
    parameter int N  = 5,
    parameter int GW = 5
) (
    input  logic [N-1:0]         halted_q_i,
    input  logic [N-1:0]         halted_in_i,
    input  logic [N-1:0][GW-1:0] group_i,
    output logic [N-1:0]         set_req_o
);

    logic [N-1:0] newly_halted;
    assign newly_halted = halted_in_i & ~halted_q_i;

    // One requester column per target; every source is scanned, so
    // simultaneous halts all contribute.
    for (genvar t = 0; t < N; t++) begin : g_target
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int s = 0; s < N; s++) begin
                if ((s != t) && newly_halted[s] &&
                    (group_i[s] != '0) && (group_i[s] == group_i[t])) begin
                    hit = 1'b1;
                end
            end
        end
        assign set_req_o[t] = hit && !halted_q_i[t] && !halted_in_i[t];
    end

endmodule

// File: rtl/hgc_halt_group.sv
module hgc_halt_group
    import hgc_pkg::*;
#(
    parameter int NUM_HARTS = 5,
    parameter int GROUP_W   = HGC_GROUP_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_HARTS-1:0] hart_halted_i,
    input  logic [NUM_HARTS-1:0] hart_resuming_i,
    input  logic [NUM_HARTS-1:0] hart_reset_i,
    output logic [NUM_HARTS-1:0] halt_req_o,
    input  logic                 reg_wr_i,
    input  logic [1:0]           reg_addr_i,
    input  logic [31:0]          reg_wdata_i,
    output logic [31:0]          reg_rdata_o
);

    localparam int SEL_W = sel_width(NUM_HARTS);
    localparam int SLOTS = 1 << SEL_W;

    typedef struct packed {
        logic [SEL_W-1:0]              sel;
        logic                          dbg_haltreq;
        logic [SLOTS-1:0]              halted;
        logic [SLOTS-1:0]              resumeack;
        logic [SLOTS-1:0]              havereset;
        logic [NUM_HARTS-1:0]          pend;
        logic [SLOTS-1:0][GROUP_W-1:0] group;
    } state_t;

    state_t st_d, st_q;

    // Hart events widened to the full select range (absent slots see none).
    logic [SLOTS-1:0] halted_pad, resuming_pad, reset_pad;
    assign halted_pad   = SLOTS'(hart_halted_i);
    assign resuming_pad = SLOTS'(hart_resuming_i);
    assign reset_pad    = SLOTS'(hart_reset_i);

    logic               ctrl_wr, whaltreq, resume_req, ack_rst, grp_wr;
    logic [SEL_W-1:0]   wsel;
    logic [GROUP_W-1:0] grp_val;
    logic [NUM_HARTS-1:0] set_req;

    hgc_regif #(
        .SEL_W (SEL_W),
        .GW    (GROUP_W)
    ) i_regif (
        .wr_i            (reg_wr_i),
        .addr_i          (reg_addr_i),
        .wdata_i         (reg_wdata_i),
        .sel_q_i         (st_q.sel),
        .haltreq_q_i     (st_q.dbg_haltreq),
        .sel_halted_i    (st_q.halted[st_q.sel]),
        .sel_resumeack_i (st_q.resumeack[st_q.sel]),
        .sel_havereset_i (st_q.havereset[st_q.sel]),
        .sel_group_i     (st_q.group[st_q.sel]),
        .ctrl_wr_o       (ctrl_wr),
        .wsel_o          (wsel),
        .whaltreq_o      (whaltreq),
        .resume_o        (resume_req),
        .ackrst_o        (ack_rst),
        .grp_wr_o        (grp_wr),
        .grp_val_o       (grp_val),
        .rdata_o         (reg_rdata_o)
    );

    hgc_group_prop #(
        .N  (NUM_HARTS),
        .GW (GROUP_W)
    ) i_group_prop (
        .halted_q_i  (st_q.halted[NUM_HARTS-1:0]),
        .halted_in_i (hart_halted_i),
        .group_i     (st_q.group[NUM_HARTS-1:0]),
        .set_req_o   (set_req)
    );

    // Next state. Priority per slot: reset > resuming > halted notice,
    // and resuming > resume request.
    always_comb begin
        st_d = st_q;

        if (ctrl_wr) begin
            st_d.sel         = wsel;
            st_d.dbg_haltreq = whaltreq;
        end

        for (int h = 0; h < SLOTS; h++) begin
            if (halted_pad[h]) begin
                st_d.halted[h] = 1'b1;
            end
            if (resume_req && (int'(wsel) == h)) begin
                st_d.resumeack[h] = 1'b0;
            end
            if (resuming_pad[h]) begin
                st_d.halted[h]    = 1'b0;
                st_d.resumeack[h] = 1'b1;
            end
            if (ack_rst && (int'(wsel) == h)) begin
                st_d.havereset[h] = 1'b0;
            end
            if (grp_wr && (int'(st_q.sel) == h)) begin
                st_d.group[h] = grp_val;
            end
            if (reset_pad[h]) begin
                st_d.havereset[h] = 1'b1;
                st_d.halted[h]    = 1'b0;
                st_d.group[h]     = '0;
            end
        end

        st_d.pend = (st_q.pend | set_req) & ~hart_halted_i & ~hart_reset_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < NUM_HARTS; i++) begin : g_req
        assign halt_req_o[i] = st_q.pend[i] ||
                               (st_q.dbg_haltreq && (st_q.sel == SEL_W'(i)));
    end

endmodule

// File: rtl/hgc_halt_group_chk.sv
module hgc_halt_group_chk #(
    parameter int N     = 5,
    parameter int SEL_W = 3,
    parameter int SLOTS = 8,
    parameter int GW    = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N-1:0]              hart_halted_i,
    input logic [N-1:0]              hart_resuming_i,
    input logic [N-1:0]              hart_reset_i,
    input logic                      reg_wr_i,
    input logic [1:0]                reg_addr_i,
    input logic [31:0]               reg_wdata_i,
    input logic [SEL_W-1:0]          sel,
    input logic [SLOTS-1:0]          halted,
    input logic [SLOTS-1:0]          resumeack,
    input logic [SLOTS-1:0]          havereset,
    input logic [N-1:0]              pend,
    input logic [SLOTS-1:0][GW-1:0]  group
);

    p_sel_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == 2'd0) |=> (sel == $past(reg_wdata_i[SEL_W-1:0])));

    for (genvar h = 0; h < N; h++) begin : g_hart
        p_pend_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[h]) |-> $past(|(hart_halted_i & ~halted[N-1:0])));

        p_group_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!(reg_wr_i && reg_addr_i == 2'd1 && reg_wdata_i[31]) && !hart_reset_i[h])
            |=> $stable(group[h]));

        p_resume_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (hart_resuming_i[h] && !hart_reset_i[h]) |=> (!halted[h] && resumeack[h]));

        p_reset_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
            hart_reset_i[h] |=> (havereset[h] && !halted[h] && group[h] == '0));

        p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[h] && !hart_halted_i[h] && !hart_reset_i[h]) |=> pend[h]);

        p_pend_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (hart_halted_i[h] || hart_reset_i[h]) |=> !pend[h]);
    end

endmodule

bind hgc_halt_group hgc_halt_group_chk #(
    .N     (NUM_HARTS),
    .SEL_W (SEL_W),
    .SLOTS (SLOTS),
    .GW    (GROUP_W)
) i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .hart_halted_i   (hart_halted_i),
    .hart_resuming_i (hart_resuming_i),
    .hart_reset_i    (hart_reset_i),
    .reg_wr_i        (reg_wr_i),
    .reg_addr_i      (reg_addr_i),
    .reg_wdata_i     (reg_wdata_i),
    .sel             (st_q.sel),
    .halted          (st_q.halted),
    .resumeack       (st_q.resumeack),
    .havereset       (st_q.havereset),
    .pend            (st_q.pend),
    .group           (st_q.group)
);

// File: tb/test_hgc_halt_group.sv
module test_hgc_halt_group;

    localparam int NH = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NH-1:0] hart_halted = '0;
    logic [NH-1:0] hart_resuming = '0;
    logic [NH-1:0] hart_reset = '0;
    logic [NH-1:0] halt_req;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    hgc_halt_group #(.NUM_HARTS(NH)) i_hgc_halt_group (
        .clk             (clk),
        .rst_n           (rst_n),
        .hart_halted_i   (hart_halted),
        .hart_resuming_i (hart_resuming),
        .hart_reset_i    (hart_reset),
        .halt_req_o      (halt_req),
        .reg_wr_i        (reg_wr),
        .reg_addr_i      (reg_addr),
        .reg_wdata_i     (reg_wdata),
        .reg_rdata_o     (reg_rdata)
    );

    typedef struct packed {
        logic [31:0] ctrl_w;
        logic [31:0] grp_w;
        logic [31:0] exp_ctrl;
        logic [31:0] exp_grp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 32'h8000_0001, 32'h0000_0000, 32'h0000_0001},
        '{32'h0000_0001, 32'h0000_0002, 32'h0000_0001, 32'h0000_0000},
        '{32'h0000_0009, 32'h8000_0002, 32'h0000_0001, 32'h0000_0002},
        '{32'h0000_0002, 32'h8000_0001, 32'h0000_0002, 32'h0000_0001},
        '{32'h0000_000B, 32'h8000_0002, 32'h0000_0003, 32'h0000_0002},
        '{32'h0000_0004, 32'h8000_0000, 32'h0000_0004, 32'h0000_0000},
        '{32'h0000_0006, 32'h8000_001F, 32'h0000_0006, 32'h0000_001F},
        '{32'h0000_000E, 32'h0000_000A, 32'h0000_0006, 32'h0000_001F},
        '{32'h0000_FFF8, 32'h0000_0003, 32'h0000_0000, 32'h0000_0001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_halt(input logic [NH-1:0] m);
        @(negedge clk);
        hart_halted = m;
        @(negedge clk);
        hart_halted = '0;
        #1;
    endtask

    task automatic pulse_resume(input logic [NH-1:0] m);
        @(negedge clk);
        hart_resuming = m;
        @(negedge clk);
        hart_resuming = '0;
        #1;
    endtask

    task automatic pulse_reset(input logic [NH-1:0] m);
        @(negedge clk);
        hart_reset = m;
        @(negedge clk);
        hart_reset = '0;
        #1;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;

        // R11: reset state
        check("R11 halt_req", 32'(halt_req), 32'h0);
        reg_read(2'd0, rd); check("R11 ctrl", rd, 32'h0);
        reg_read(2'd1, rd); check("R11 group", rd, 32'h0);
        reg_read(2'd2, rd); check("R11/R8 status", rd, 32'h0000_000C);

        // R1, R5: select masking and gated group writes
        for (int i = 0; i < NV; i++) begin
            reg_write(2'd0, VECS[i].ctrl_w);
            reg_write(2'd1, VECS[i].grp_w);
            reg_read(2'd0, rd); check("R1 ctrl readback", rd, VECS[i].exp_ctrl);
            reg_read(2'd1, rd); check("R5 group readback", rd, VECS[i].exp_grp);
        end

        // R2: nonexistent hart keeps its group
        reg_write(2'd0, 32'h0000_0006);
        reg_read(2'd1, rd); check("R2 absent hart group", rd, 32'h0000_001F);
        reg_write(2'd0, 32'h0000_0000);

        // Groups now: h0=1 h1=2 h2=1 h3=2 h4=0
        // R10, R3: two halts in one cycle, two groups
        pulse_halt(5'b00011);
        check("R10/R3 simultaneous", 32'(halt_req), 32'b01100);

        // R9: held over idle cycles
        repeat (3) @(negedge clk);
        #1;
        check("R9 held", 32'(halt_req), 32'b01100);

        // R9: ORed with debugger request on selected hart
        reg_write(2'd0, 32'h8000_0004);
        #1;
        check("R9 or debugger", 32'(halt_req), 32'b11100);
        reg_read(2'd0, rd); check("R1 haltreq readback", rd, 32'h8000_0004);

        // R9: cleared by target halting
        pulse_halt(5'b01100);
        check("R9 cleared", 32'(halt_req), 32'b10000);
        reg_write(2'd0, 32'h0000_0004);
        #1;
        check("R9 debugger drop", 32'(halt_req), 32'b00000);

        // R8: status encoding
        reg_read(2'd2, rd); check("R8 running", rd, 32'h0000_000C);
        reg_write(2'd0, 32'h0000_0000);
        reg_read(2'd2, rd); check("R8 halted", rd, 32'h0000_0003);

        // R6: resume ack set and cleared
        pulse_resume(5'b00001);
        reg_read(2'd2, rd); check("R6 resumeack set", rd, 32'h0000_001C);
        reg_write(2'd0, 32'h4000_0000);
        reg_read(2'd2, rd); check("R6 resumeack cleared", rd, 32'h0000_000C);
        reg_read(2'd0, rd); check("R6 resume bit not stored", rd, 32'h0);

        // R4: group 0 halts propagate nothing
        reg_write(2'd1, 32'h8000_0000);
        pulse_halt(5'b00001);
        check("R4 group zero", 32'(halt_req), 32'b00000);

        // R4: repeated halted notice propagates nothing
        pulse_resume(5'b00010);
        reg_write(2'd1, 32'h8000_0002);
        pulse_halt(5'b00001);
        check("R4 already halted", 32'(halt_req), 32'b00000);

        // R3: single source reaches its running group mate only
        pulse_resume(5'b00001);
        pulse_halt(5'b00001);
        check("R3 single source", 32'(halt_req), 32'b00010);
        pulse_halt(5'b00010);
        check("R9 mate halted", 32'(halt_req), 32'b00000);

        // R7: hart reset and acknowledge
        pulse_reset(5'b01000);
        reg_write(2'd0, 32'h0000_0003);
        reg_read(2'd2, rd); check("R7 havereset", rd, 32'h0000_006C);
        reg_read(2'd1, rd); check("R7 group cleared", rd, 32'h0);
        reg_write(2'd0, 32'h2000_0003);
        reg_read(2'd2, rd); check("R7 ack", rd, 32'h0000_000C);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule